// File: doc/BRIEF.md
# Counter-Extended One-Shot Controller

This block makes long output pulses whose length is set by a number rather than by a long timer. A gated square-wave generator produces a stream of periods. A period counter tallies them, and the counter's busy state is the generator's run enable. A rising edge on the trigger input loads the count limit, clears the tally and starts the generator. The pulse output stays high until the requested number of periods has completed. At that point the busy state drops, the generator stops, and a single-cycle completion strobe is raised.

The generator is a cycle-accurate model of a free-running oscillator with a stretched first segment. Its first high segment lasts `FIRST_CYC` clock cycles. After that it alternates low and high segments of `HALF_CYC` cycles each. One full period is therefore `2*HALF_CYC` cycles. Because the first segment is longer, the pulse lasts `(N-1)` full periods plus the first segment plus one half period. A short base period can thus give pulses of many thousands of cycles.

Top module: `cntx_oneshot`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pulse_o`, `osc_o` and `done_o` are all low.
- R2: A rising edge of `trig_i` (high now, low in the previous cycle) makes `pulse_o` and `osc_o` high in the very next cycle.
- R3: For a latched count N of 1 or more, `pulse_o` stays high for exactly `FIRST_CYC + HALF_CYC + (N-1)*2*HALF_CYC` consecutive cycles.
- R4: A count of 0 on `count_n_i` gives the same pulse length as a count of 1.
- R5: `count_n_i` is sampled only on the trigger edge. Changing it while a pulse runs does not alter that pulse's length.
- R6: Counting cycle p from 0 at the start of the pulse, `osc_o` is high for p below `FIRST_CYC`. After that, `osc_o` is low for the first `HALF_CYC` cycles of each period and high for the second `HALF_CYC`. `osc_o` is low whenever `pulse_o` is low.
- R7: A new trigger edge during an active pulse restarts the count. The pulse then runs the full R3 length for the newly latched N, counted from the retrigger.
- R8: `done_o` is high for exactly one cycle, namely the first cycle in which `pulse_o` is low after a pulse ends by itself.
- R9: A trigger edge presented in the same cycle that `done_o` is high starts a new pulse at once, with no dead time.
- R10: Holding `trig_i` high does not retrigger. The pulse ends after its normal length, and no new pulse starts until `trig_i` goes low and then high again.
- R11: A trigger edge that arrives on the pulse's final cycle restarts the pulse. In that case `pulse_o` does not drop and no `done_o` strobe is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger; a rising edge starts or restarts a pulse |
| count_n_i | input | CNT_W | Number of generator periods per pulse, latched on the trigger edge |
| pulse_o | output | 1 | Extended pulse; high while the period count is incomplete |
| osc_o | output | 1 | Gated generator waveform |
| done_o | output | 1 | One-cycle strobe when a pulse ends by itself |

## Verification
The bench builds the block with `CNT_W=4`, `FIRST_CYC=3` and `HALF_CYC=2`. With these values every count from 0 to 15 can be swept completely, and the longest pulse is only 61 cycles. The short segments also place every segment boundary of the generator within a few cycles of the trigger. This lets retriggers be swept across each phase of the first period, and lets a trigger be landed exactly on a pulse's final cycle. The expected length and the expected generator level in every cycle are computed from the R3 and R6 formulas.

// File: rtl/cntx_pkg.sv
package cntx_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } osc_phase_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cntx_osc.sv
module cntx_osc
    import cntx_pkg::*;
#(
    parameter int FIRST_CYC = 5,
    parameter int HALF_CYC  = 4,
    parameter int TMR_W     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic run_i,
    input  logic halt_i,
    output logic osc_o,
    output logic wrap_o
);

    localparam logic [TMR_W-1:0] FIRST_LOAD = TMR_W'(FIRST_CYC - 1);
    localparam logic [TMR_W-1:0] HALF_LOAD  = TMR_W'(HALF_CYC - 1);

    typedef struct packed {
        osc_phase_e       ph;
        logic [TMR_W-1:0] tmr;
    } osc_state_t;

    osc_state_t st_d, st_q;
    logic       wrap_d;

    always_comb begin
        st_d   = st_q;
        wrap_d = 1'b0;
        if (start_i) begin
            st_d.ph  = PH_HIGH;
            st_d.tmr = FIRST_LOAD;
        end else if (run_i) begin
            if (st_q.tmr != '0) begin
                st_d.tmr = st_q.tmr - TMR_W'(1);
            end else if (st_q.ph == PH_HIGH) begin
                st_d.ph  = PH_LOW;
                st_d.tmr = HALF_LOAD;
            end else begin
                wrap_d = 1'b1;
                if (halt_i) begin
                    st_d.ph  = PH_LOW;
                    st_d.tmr = '0;
                end else begin
                    st_d.ph  = PH_HIGH;
                    st_d.tmr = HALF_LOAD;
                end
            end
        end else begin
            st_d.ph  = PH_LOW;
            st_d.tmr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_LOW, tmr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign osc_o  = (st_q.ph == PH_HIGH);
    assign wrap_o = wrap_d;

endmodule

// File: rtl/cntx_nctr.sv
module cntx_nctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] n_i,
    input  logic             wrap_i,
    output logic             active_o,
    output logic             last_o,
    output logic             done_o
);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             done;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       last;

    assign last = st_q.active && (st_q.cnt == (st_q.lim - CNT_W'(1)));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.lim    = (n_i == '0) ? CNT_W'(1) : n_i;
        end else if (st_q.active && wrap_i) begin
            if (last) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{active: 1'b0, cnt: '0, lim: CNT_W'(1), done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign last_o   = last;
    assign done_o   = st_q.done;

endmodule

// File: rtl/cntx_oneshot.sv
module cntx_oneshot
    import cntx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int FIRST_CYC = 5,
    parameter int HALF_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] count_n_i,
    output logic             pulse_o,
    output logic             osc_o,
    output logic             done_o
);

    localparam int TMR_W = $clog2(max_of(FIRST_CYC, HALF_CYC) + 1);

    typedef struct packed {
        logic trig_prev;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       start;
    logic       active;
    logic       last;
    logic       wrap;

    always_comb begin
        st_d           = st_q;
        st_d.trig_prev = trig_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{trig_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign start = trig_i && !st_q.trig_prev && !rst;

    cntx_osc #(
        .FIRST_CYC (FIRST_CYC),
        .HALF_CYC  (HALF_CYC),
        .TMR_W     (TMR_W)
    ) u_osc (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .run_i   (active),
        .halt_i  (last),
        .osc_o   (osc_o),
        .wrap_o  (wrap)
    );

    cntx_nctr #(
        .CNT_W (CNT_W)
    ) u_nctr (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .n_i      (count_n_i),
        .wrap_i   (wrap),
        .active_o (active),
        .last_o   (last),
        .done_o   (done_o)
    );

    assign pulse_o = active;

endmodule

module cntx_oneshot_chk (
    input logic clk,
    input logic rst,
    input logic trig_i,
    input logic pulse_o,
    input logic osc_o,
    input logic done_o
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!pulse_o && !osc_o && !done_o));

    // R2
    a_r2_edge_starts: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_i) |=> (pulse_o && osc_o));

    // R6
    a_r6_osc_gated: assert property (@(posedge clk) disable iff (rst)
        !pulse_o |-> !osc_o);

    // R8
    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_o) |-> done_o);

    // R8
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !pulse_o);

    // R8
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind cntx_oneshot cntx_oneshot_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig_i),
    .pulse_o (pulse_o),
    .osc_o   (osc_o),
    .done_o  (done_o)
);

// File: tb/sim_cntx_oneshot.sv
module sim_cntx_oneshot;

    localparam int CW = 4;
    localparam int FC = 3;
    localparam int HC = 2;

    logic          clk  = 1'b0;
    logic          rst  = 1'b1;
    logic          trig = 1'b0;
    logic [CW-1:0] nval = '0;
    logic          pulse, osc, done;

    int vecs = 0;
    int bad  = 0;

    always #10 clk = ~clk;

    cntx_oneshot #(.CNT_W(CW), .FIRST_CYC(FC), .HALF_CYC(HC)) u0 (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig),
        .count_n_i (nval),
        .pulse_o   (pulse),
        .osc_o     (osc),
        .done_o    (done)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int n);
        int nn = (n == 0) ? 1 : n;
        return FC + HC + (nn - 1) * 2 * HC;
    endfunction

    function automatic int exp_osc(input int p);
        if (p < FC) return 1;
        return (((p - FC) / HC) % 2 == 0) ? 0 : 1;
    endfunction

    // called at a negedge; returns at the negedge where the pulse should be high
    task automatic fire(input int n);
        trig = 1'b1;
        nval = CW'(n);
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic measure(input string req, input int exp, input int alt_n);
        int len = 0;
        int oscbad = 0;
        while (pulse === 1'b1 && len < 1000) begin
            if (osc !== exp_osc(len)) oscbad++;
            len++;
            if (len == 2 && alt_n >= 0) nval = CW'(alt_n);
            @(negedge clk);
        end
        chk(req, len, exp);
        chk("R6 osc waveform", oscbad, 0);
        chk("R6 osc idle", int'(osc), 0);
    endtask

    task automatic end_chk();
        chk("R8 done high", int'(done), 1);
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vecs++;
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 in reset", {29'd0, pulse, osc, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {29'd0, pulse, osc, done}, 0);

        // R3 / R4 sweep over every count
        for (int n = 0; n < (1 << CW); n++) begin
            fire(n);
            chk("R2 start", {30'd0, pulse, osc}, 3);
            measure((n == 0) ? "R4 zero count" : "R3 length", exp_len(n), -1);
            end_chk();
            repeat (2) @(negedge clk);
        end

        // R5 count changes mid-pulse are ignored
        fire(2);
        measure("R5 ignore raise", exp_len(2), 9);
        end_chk();
        @(negedge clk);
        fire(9);
        measure("R5 ignore lower", exp_len(9), 1);
        end_chk();
        @(negedge clk);

        // R7 retrigger at each phase of the first period
        for (int k = 1; k <= 6; k++) begin
            fire(3);
            repeat (k) @(negedge clk);
            chk("R7 no early done", int'(done), 0);
            fire(2);
            measure("R7 retrigger", exp_len(2), -1);
            end_chk();
            @(negedge clk);
        end

        // R9 immediate re-trigger on the done cycle
        fire(1);
        measure("R9 first", exp_len(1), -1);
        chk("R9 done seen", int'(done), 1);
        fire(2);
        chk("R9 restart", int'(pulse), 1);
        measure("R9 second", exp_len(2), -1);
        end_chk();
        @(negedge clk);

        // R10 level-held trigger does not retrigger
        trig = 1'b1;
        nval = CW'(2);
        @(negedge clk);
        measure("R10 held length", exp_len(2), -1);
        end_chk();
        repeat (3) @(negedge clk);
        chk("R10 no new pulse", int'(pulse), 0);
        trig = 1'b0;
        @(negedge clk);

        // R11 trigger on the final cycle
        fire(1);
        repeat (exp_len(1) - 1) @(negedge clk);
        chk("R11 still high", int'(pulse), 1);
        trig = 1'b1;
        nval = CW'(1);
        @(negedge clk);
        trig = 1'b0;
        chk("R11 no drop", {30'd0, pulse, done}, 2);
        measure("R11 restarted length", exp_len(1), -1);
        end_chk();

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule